// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Sequencer

This block sits between a host and a parallel NOR flash that follows the common unlock-based command set. A single start pulse from the host launches either a one-word program or a sector erase over a range of uniformly sized sectors. The block then generates every bus cycle the flash needs. First it writes a two-cycle unlock, then the operation command, then the data word or the erase confirm. After that it polls the device until the internal operation ends.

Polling works in one of two ways. In toggle mode the block reads the same location twice and treats a difference between the two reads as busy. In status mode it writes a read-status command and then waits for the done bit. Each poll loop has a clock-count limit. When busy outlasts that limit, the block writes a reset command, waits a short recovery time and reports a timeout.

Before a program starts, the block reads the target word. If any bit that should end up as 1 is already 0, it refuses the program. During an erase range it skips any sector whose protect bit is set. A compatibility flag moves the unlock addresses for dual-width parts running in their narrow mode. The erase confirm byte is supplied by the host, so the same block can drive parts that offer small and large erase granularities.

Top module: `nor_seq`

## Requirements
- R1: A program issues four writes in this order: 0xAA at unlock address A, 0x55 at unlock address B, 0xA0 at unlock address A, and then the data word at the target address.
- R2: An erase of one sector issues six writes in this order: 0xAA at A, 0x55 at B, 0x80 at A, 0xAA at A, 0x55 at B, and then the erase confirm byte at the sector base address. The sector base is the address with its low SECT_W bits cleared.
- R3: With compat_i low, unlock address A is 0x555 and B is 0x2AA. With compat_i high, A is 0xAAA and B is 0x555.
- R4: A program first reads the target. If (read AND data) is not equal to data, the operation ends with status 1 (I/O error), issues no write cycle, and leaves the flash contents unchanged.
- R5: In toggle mode (sr_poll_i low) the block reads the sector base twice per poll and stays busy while the two values differ. Completion reports status 0.
- R6: In status mode (sr_poll_i high) every poll writes 0x70 at unlock address A and then reads once. The device counts as busy while bit 7 of that read is 0.
- R7: If the device is still busy once tmo_i clocks have passed since the last command write, the block writes 0xF0 at the sector base, waits RECOV_CLKS clocks, and ends with status 2 (timeout).
- R8: An erase covers every sector from the sector of addr_i up to the sector of end_addr_i, in ascending order. It skips each sector whose protect_i bit is set; a skipped sector gets no write cycle and keeps its contents.
- R9: The erase confirm byte is erase_cmd_i, for example 0x30 for large sectors or 0x50 for small sectors.
- R10: Each bus cycle holds its strobe low for exactly WR_PULSE clocks. Address and write data stay stable while the write strobe is low. The write and read strobes are never low at the same time.
- R11: busy_o rises in the clock after an accepted start. A start that arrives while busy_o is high is ignored. done_o is a one-clock pulse in which busy_o is already low and status_o holds the result.
- R12: After reset both strobes are high, and busy_o, done_o and status_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation (accepted only while idle) |
| op_erase_i | input | 1 | 1 = erase range, 0 = program one word |
| addr_i | input | AW | Program target, or first address of the erase range |
| end_addr_i | input | AW | Last address of the erase range |
| data_i | input | DW | Word to program |
| tmo_i | input | TW | Busy limit in clocks |
| compat_i | input | 1 | Use the narrow-mode unlock addresses |
| sr_poll_i | input | 1 | 1 = status-register polling, 0 = toggle polling |
| erase_cmd_i | input | 8 | Sector erase confirm byte |
| protect_i | input | 2**(AW-SECT_W) | Per-sector protect bits |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse |
| status_o | output | 2 | 0 ok, 1 I/O error, 2 timeout |
| f_addr_o | output | AW | Flash address |
| f_dq_o | output | DW | Flash write data |
| f_dq_i | input | DW | Flash read data |
| f_we_no | output | 1 | Flash write strobe, active low |
| f_oe_no | output | 1 | Flash read strobe, active low |

## Verification
The bench builds the block with AW=12, DW=8, SECT_W=8, WR_PULSE=2, TW=16 and RECOV_CLKS=4. With 12 address bits both unlock address sets fit, including the 0xAAA form. The 8-bit sector field gives sixteen 256-word sectors, enough for a multi-sector erase range with a protected sector in the middle. A 16-bit timeout field allows both a generous limit and a tight limit of 40 clocks against a model that never finishes, which is how the reset-and-recover path is reached.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_IOERR = 2'd1, RES_TMO = 2'd2} res_e;

  localparam logic [7:0] C_UNLK_A  = 8'hAA;
  localparam logic [7:0] C_UNLK_B  = 8'h55;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_ERASE   = 8'h80;
  localparam logic [7:0] C_RESET   = 8'hF0;
  localparam logic [7:0] C_RDSTAT  = 8'h70;
  localparam int         DONE_BIT  = 7;

  // second=0 -> first unlock address, second=1 -> second unlock address
  function automatic logic [11:0] unlock_adr(input logic compat, input logic second);
    if (compat) return second ? 12'h555 : 12'hAAA;
    else        return second ? 12'h2AA : 12'h555;
  endfunction
endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int AW    = 12,
  parameter int DW    = 8,
  parameter int PULSE = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] f_addr_o,
  output logic [DW-1:0] f_dq_o,
  input  logic [DW-1:0] f_dq_i,
  output logic          f_we_no,
  output logic          f_oe_no
);
  localparam int CW = $clog2(PULSE + 1);
  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STRB, B_HOLD} bst_e;

  bst_e          st;
  logic          wr_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= B_IDLE; wr_q <= 1'b0; cnt <= '0; ack_o <= 1'b0;
      rdata_o <= '0; f_addr_o <= '0; f_dq_o <= '0;
      f_we_no <= 1'b1; f_oe_no <= 1'b1;
    end else begin
      ack_o <= 1'b0;
      case (st)
        B_IDLE: if (req_i) begin
          f_addr_o <= addr_i; f_dq_o <= wdata_i; wr_q <= wr_i; st <= B_SETUP;
        end
        B_SETUP: begin
          if (wr_q) f_we_no <= 1'b0; else f_oe_no <= 1'b0;
          cnt <= CW'(1); st <= B_STRB;
        end
        B_STRB: if (cnt == CW'(PULSE)) begin
          f_we_no <= 1'b1; f_oe_no <= 1'b1;
          if (!wr_q) rdata_o <= f_dq_i;
          st <= B_HOLD;
        end else cnt <= cnt + 1'b1;
        default: begin ack_o <= 1'b1; st <= B_IDLE; end
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_step.sv
module nor_cmd_step #(
  parameter int AW     = 12,
  parameter int DW     = 8,
  parameter int SECT_W = 8
) (
  input  logic          erase_i,
  input  logic [2:0]    step_i,
  input  logic          compat_i,
  input  logic [AW-1:0] tgt_i,
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] data_i,
  input  logic [7:0]    ecmd_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          last_o
);
  import nor_seq_pkg::*;
  logic [AW-1:0] ua, ub;
  assign ua = AW'(unlock_adr(compat_i, 1'b0));
  assign ub = AW'(unlock_adr(compat_i, 1'b1));

  always_comb begin
    addr_o = ua; data_o = DW'(C_UNLK_A); last_o = 1'b0;
    if (!erase_i) begin
      case (step_i)
        3'd0:    begin addr_o = ua; data_o = DW'(C_UNLK_A); end
        3'd1:    begin addr_o = ub; data_o = DW'(C_UNLK_B); end
        3'd2:    begin addr_o = ua; data_o = DW'(C_PROG);   end
        default: begin addr_o = tgt_i; data_o = data_i; last_o = 1'b1; end
      endcase
    end else begin
      case (step_i)
        3'd0, 3'd3: begin addr_o = ua; data_o = DW'(C_UNLK_A); end
        3'd1, 3'd4: begin addr_o = ub; data_o = DW'(C_UNLK_B); end
        3'd2:       begin addr_o = ua; data_o = DW'(C_ERASE);  end
        default:    begin addr_o = base_i; data_o = DW'(ecmd_i); last_o = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/nor_tmo_timer.sv
module nor_tmo_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [TW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (clr_i)         cnt_o <= '0;
    else if (~&cnt_o)       cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/nor_seq.sv
module nor_seq #(
  parameter int AW         = 12,
  parameter int DW         = 8,
  parameter int SECT_W     = 8,
  parameter int WR_PULSE   = 3,
  parameter int TW         = 16,
  parameter int RECOV_CLKS = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         op_erase_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [AW-1:0]                end_addr_i,
  input  logic [DW-1:0]                data_i,
  input  logic [TW-1:0]                tmo_i,
  input  logic                         compat_i,
  input  logic                         sr_poll_i,
  input  logic [7:0]                   erase_cmd_i,
  input  logic [(1<<(AW-SECT_W))-1:0]  protect_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [1:0]                   status_o,
  output logic [AW-1:0]                f_addr_o,
  output logic [DW-1:0]                f_dq_o,
  input  logic [DW-1:0]                f_dq_i,
  output logic                         f_we_no,
  output logic                         f_oe_no
);
  import nor_seq_pkg::*;
  localparam int NW    = AW - SECT_W;
  localparam int NSECT = 1 << NW;

  typedef enum logic [3:0] {S_IDLE, S_CHK, S_SECT, S_CMD, S_PWR, S_PR1, S_PR2,
                            S_EVAL, S_RST, S_RWAIT, S_FIN} st_e;
  st_e st;

  logic             op_q, compat_q, sr_q, issued;
  logic [AW-1:0]    tgt_q;
  logic [DW-1:0]    dat_q, r1, r2, bus_rd;
  logic [TW-1:0]    tmo_q, tcnt;
  logic [7:0]       ecmd_q;
  logic [NSECT-1:0] prot_q;
  logic [NW:0]      cur_s, last_s;   // one spare bit so the range walk cannot wrap
  logic [2:0]       step;
  res_e             res_q;

  logic             bus_req, bus_wr, bus_ack, step_last, tclr, poll_busy;
  logic [AW-1:0]    bus_addr, step_addr, base;
  logic [DW-1:0]    bus_wd, step_data;

  assign base = op_q ? {cur_s[NW-1:0], {SECT_W{1'b0}}} : {tgt_q[AW-1:SECT_W], {SECT_W{1'b0}}};

  nor_cmd_step #(.AW(AW), .DW(DW), .SECT_W(SECT_W)) u_step (
    .erase_i(op_q), .step_i(step), .compat_i(compat_q), .tgt_i(tgt_q), .base_i(base),
    .data_i(dat_q), .ecmd_i(ecmd_q), .addr_o(step_addr), .data_o(step_data), .last_o(step_last));

  nor_bus_cycle #(.AW(AW), .DW(DW), .PULSE(WR_PULSE)) u_bus (
    .clk_i, .rst_ni, .req_i(bus_req), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wd),
    .ack_o(bus_ack), .rdata_o(bus_rd), .f_addr_o, .f_dq_o, .f_dq_i, .f_we_no, .f_oe_no);

  nor_tmo_timer #(.TW(TW)) u_tmr (.clk_i, .rst_ni, .clr_i(tclr), .cnt_o(tcnt));

  assign tclr      = bus_ack && ((st == S_CMD && step_last) || st == S_RST);
  assign poll_busy = sr_q ? !r1[DONE_BIT] : (r1 != r2);

  always_comb begin
    bus_req = 1'b0; bus_wr = 1'b0; bus_addr = base; bus_wd = '0;
    case (st)
      S_CHK: begin bus_req = !issued; bus_addr = tgt_q; end
      S_CMD: begin bus_req = !issued; bus_wr = 1'b1; bus_addr = step_addr; bus_wd = step_data; end
      S_PWR: begin
        bus_req = !issued; bus_wr = 1'b1;
        bus_addr = AW'(unlock_adr(compat_q, 1'b0)); bus_wd = DW'(C_RDSTAT);
      end
      S_PR1, S_PR2: bus_req = !issued;
      S_RST: begin bus_req = !issued; bus_wr = 1'b1; bus_wd = DW'(C_RESET); end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; op_q <= 1'b0; compat_q <= 1'b0; sr_q <= 1'b0; issued <= 1'b0;
      tgt_q <= '0; dat_q <= '0; r1 <= '0; r2 <= '0; tmo_q <= '0; ecmd_q <= '0;
      prot_q <= '0; cur_s <= '0; last_s <= '0; step <= '0; res_q <= RES_OK;
      busy_o <= 1'b0; done_o <= 1'b0; status_o <= 2'd0;
    end else begin
      done_o <= 1'b0;
      if (bus_req) issued <= 1'b1;
      if (bus_ack) issued <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          op_q <= op_erase_i; tgt_q <= addr_i; dat_q <= data_i; tmo_q <= tmo_i;
          compat_q <= compat_i; sr_q <= sr_poll_i; ecmd_q <= erase_cmd_i; prot_q <= protect_i;
          cur_s <= {1'b0, addr_i[AW-1:SECT_W]}; last_s <= {1'b0, end_addr_i[AW-1:SECT_W]};
          step <= '0; busy_o <= 1'b1;
          st <= op_erase_i ? S_SECT : S_CHK;
        end
        S_CHK: if (bus_ack) begin
          if ((bus_rd & dat_q) != dat_q) begin res_q <= RES_IOERR; st <= S_FIN; end
          else st <= S_CMD;
        end
        S_SECT: begin
          step <= '0;
          if (cur_s > last_s)              begin res_q <= RES_OK; st <= S_FIN; end
          else if (prot_q[cur_s[NW-1:0]])  cur_s <= cur_s + 1'b1;
          else                             st <= S_CMD;
        end
        S_CMD: if (bus_ack) begin
          if (step_last) st <= sr_q ? S_PWR : S_PR1;
          else           step <= step + 1'b1;
        end
        S_PWR: if (bus_ack) st <= S_PR1;
        S_PR1: if (bus_ack) begin r1 <= bus_rd; st <= sr_q ? S_EVAL : S_PR2; end
        S_PR2: if (bus_ack) begin r2 <= bus_rd; st <= S_EVAL; end
        S_EVAL: begin
          if (!poll_busy) begin
            if (op_q) begin cur_s <= cur_s + 1'b1; st <= S_SECT; end
            else      begin res_q <= RES_OK; st <= S_FIN; end
          end else if (tcnt >= tmo_q) st <= S_RST;
          else                        st <= sr_q ? S_PWR : S_PR1;
        end
        S_RST:   if (bus_ack) st <= S_RWAIT;
        S_RWAIT: if (tcnt >= TW'(RECOV_CLKS)) begin res_q <= RES_TMO; st <= S_FIN; end
        default: begin
          busy_o <= 1'b0; done_o <= 1'b1; status_o <= res_q; st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
  parameter int AW       = 12,
  parameter int DW       = 8,
  parameter int WR_PULSE = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] f_addr_o,
  input logic [DW-1:0] f_dq_o,
  input logic          f_we_no,
  input logic          f_oe_no
);
  logic [15:0] low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_cnt <= '0;
    else if (!f_we_no) low_cnt <= low_cnt + 1'b1;
    else               low_cnt <= '0;
  end

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!f_we_no && !f_oe_no));
  assert_we_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!f_we_no && $past(!f_we_no)) |-> ($stable(f_addr_o) && $stable(f_dq_o)));
  assert_we_width_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(f_we_no) |-> (low_cnt == 16'(WR_PULSE)));
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_start_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

bind nor_seq nor_seq_chk #(.AW(AW), .DW(DW), .WR_PULSE(WR_PULSE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .f_addr_o(f_addr_o), .f_dq_o(f_dq_o), .f_we_no(f_we_no), .f_oe_no(f_oe_no));

// File: tb/nor_seq_tb.sv
`timescale 1ns/1ps
module nor_seq_tb;
  localparam int AW = 12, DW = 8, SECT_W = 8, WR_PULSE = 2, TW = 16, RECOV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 0, op_erase = 0, compat = 0, sr_poll = 0;
  logic [AW-1:0] addr = '0, end_addr = '0;
  logic [DW-1:0] data = '0;
  logic [TW-1:0] tmo = '0;
  logic [7:0] ecmd = 8'h30;
  logic [15:0] prot = '0;
  logic busy, done;
  logic [1:0] status;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_dq_o, f_dq_i;
  logic f_we_n, f_oe_n;

  nor_seq #(.AW(AW), .DW(DW), .SECT_W(SECT_W), .WR_PULSE(WR_PULSE), .TW(TW), .RECOV_CLKS(RECOV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_erase_i(op_erase), .addr_i(addr),
    .end_addr_i(end_addr), .data_i(data), .tmo_i(tmo), .compat_i(compat), .sr_poll_i(sr_poll),
    .erase_cmd_i(ecmd), .protect_i(prot), .busy_o(busy), .done_o(done), .status_o(status),
    .f_addr_o(f_addr), .f_dq_o(f_dq_o), .f_dq_i(f_dq_i), .f_we_no(f_we_n), .f_oe_no(f_oe_n));

  int n_chk = 0, n_err = 0, n_wr = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_err++; $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp); end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] mem [0:4095];
  int  busy_len = 2, busy_left = 0;
  bit  busy_inf = 0, inf_act = 0, stat_rd = 0, tog = 0, prog_arm = 0, erase_arm = 0;
  logic [7:0] prev_d = '0;
  wire m_busy = inf_act || (busy_left > 0);

  always_comb begin
    if (stat_rd)     f_dq_i = m_busy ? 8'h00 : 8'h80;
    else if (m_busy) f_dq_i = {1'b0, tog, 6'b0};
    else             f_dq_i = mem[f_addr];
  end

  always @(posedge f_we_n) if (rst_n) begin
    if (prog_arm) begin
      mem[f_addr] = mem[f_addr] & f_dq_o; prog_arm = 0;
      busy_left = busy_len; inf_act = busy_inf;
    end else if (f_dq_o == 8'hF0) begin
      busy_left = 0; inf_act = 0; erase_arm = 0;
    end else if (f_dq_o == 8'hA0) prog_arm = 1;
    else if (f_dq_o == 8'h80) erase_arm = 1;
    else if (erase_arm && prev_d == 8'h55 && (f_dq_o == 8'h30 || f_dq_o == 8'h50)) begin
      for (int i = 0; i < 256; i++) mem[{f_addr[11:8], 8'(i)}] = 8'hFF;
      erase_arm = 0; busy_left = busy_len; inf_act = busy_inf;
    end else if (f_dq_o == 8'h70) stat_rd = 1;
    prev_d = f_dq_o;
  end

  always @(posedge f_oe_n) if (rst_n) begin
    stat_rd = 0; tog = ~tog;
    if (busy_left > 0) busy_left--;
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
  wr_t exp_q[$];
  realtime t_fall;
  logic [AW-1:0] a_fall;
  logic [DW-1:0] d_fall;
  bit seen_fall = 0;

  always @(negedge f_we_n) if (rst_n) begin
    t_fall = $realtime; a_fall = f_addr; d_fall = f_dq_o; seen_fall = 1;
  end

  always @(posedge f_we_n) if (rst_n && seen_fall) begin
    wr_t e;
    seen_fall = 0; n_wr++;
    chk(int'(($realtime - t_fall) / 10.0) == WR_PULSE, "R10", "write strobe clocks",
        int'(($realtime - t_fall) / 10.0), WR_PULSE);
    chk(a_fall == f_addr && d_fall == f_dq_o, "R10", "addr/data stable under strobe",
        {f_addr, f_dq_o}, {a_fall, d_fall});
    if (exp_q.size() == 0) chk(0, "R1", "unexpected write addr/data", {f_addr, f_dq_o}, 0);
    else begin
      e = exp_q.pop_front();
      chk(e.a == f_addr, "R1", "write address", f_addr, e.a);
      chk(e.d == f_dq_o, "R1", "write data", f_dq_o, e.d);
    end
  end

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_t e; e.a = a; e.d = d; exp_q.push_back(e);
  endtask
  function automatic logic [AW-1:0] ua(input bit c); return c ? 12'hAAA : 12'h555; endfunction
  function automatic logic [AW-1:0] ub(input bit c); return c ? 12'h555 : 12'h2AA; endfunction
  task automatic exp_prog(input logic [AW-1:0] t, input logic [7:0] d, input bit c);
    push(ua(c), 8'hAA); push(ub(c), 8'h55); push(ua(c), 8'hA0); push(t, d);
  endtask
  task automatic exp_erase(input logic [AW-1:0] b, input logic [7:0] ec, input bit c);
    push(ua(c), 8'hAA); push(ub(c), 8'h55); push(ua(c), 8'h80);
    push(ua(c), 8'hAA); push(ub(c), 8'h55); push(b, ec);
  endtask

  task automatic run_op(input string req, input bit er, input logic [AW-1:0] a, input logic [AW-1:0] e,
                        input logic [7:0] d, input logic [TW-1:0] t, input bit c, input bit sr,
                        input logic [7:0] ec, input logic [1:0] exp_st, input bit poke);
    @(negedge clk);
    op_erase = er; addr = a; end_addr = e; data = d; tmo = t; compat = c; sr_poll = sr; ecmd = ec;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R11", "busy after start", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      op_erase = ~er; addr = 12'h0F0; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (done !== 1'b1) @(negedge clk);
    chk(busy === 1'b0, "R11", "busy low with done", busy, 0);
    chk(status === exp_st, req, "status", status, exp_st);
    @(negedge clk);
    chk(done === 1'b0, "R11", "done one cycle", done, 0);
    chk(exp_q.size() == 0, req, "missing writes", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #2_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    int w0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(f_we_n === 1 && f_oe_n === 1, "R12", "strobes in reset", {f_we_n, f_oe_n}, 3);
    chk(busy === 0 && done === 0 && status === 0, "R12", "outputs in reset", {busy, done, status}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R5: program, toggle polling
    busy_len = 3; exp_prog(12'h123, 8'h0F, 0);
    run_op("R5", 0, 12'h123, 0, 8'h0F, 16'd1000, 0, 0, 8'h30, 2'd0, 0);
    chk(mem[12'h123] == 8'h0F, "R1", "programmed word", mem[12'h123], 8'h0F);

    // R4: not erased enough -> I/O error, no writes
    w0 = n_wr;
    run_op("R4", 0, 12'h123, 0, 8'hF0, 16'd1000, 0, 0, 8'h30, 2'd1, 0);
    chk(n_wr == w0, "R4", "write count on refusal", n_wr - w0, 0);
    chk(mem[12'h123] == 8'h0F, "R4", "word untouched", mem[12'h123], 8'h0F);
    // R4: subset bits are allowed
    exp_prog(12'h123, 8'h05, 0);
    run_op("R4", 0, 12'h123, 0, 8'h05, 16'd1000, 0, 0, 8'h30, 2'd0, 0);
    chk(mem[12'h123] == 8'h05, "R4", "overprogram subset", mem[12'h123], 8'h05);

    // R3: compatibility unlock addresses
    exp_prog(12'h124, 8'h3C, 1);
    run_op("R3", 0, 12'h124, 0, 8'h3C, 16'd1000, 1, 0, 8'h30, 2'd0, 0);

    // R6: status-register polling, 3 busy reads -> four 0x70 writes
    busy_len = 3; exp_prog(12'h210, 8'h11, 0);
    for (int k = 0; k < 4; k++) push(12'h555, 8'h70);
    run_op("R6", 0, 12'h210, 0, 8'h11, 16'd1000, 0, 1, 8'h30, 2'd0, 0);
    chk(mem[12'h210] == 8'h11, "R6", "programmed word", mem[12'h210], 8'h11);

    // R2 R9: single-sector erase with small-sector byte
    busy_len = 2; mem[12'h310] = 8'h00;
    exp_erase(12'h300, 8'h50, 0);
    run_op("R9", 1, 12'h340, 12'h3FF, 0, 16'd1000, 0, 0, 8'h50, 2'd0, 0);
    chk(mem[12'h310] == 8'hFF, "R2", "sector erased", mem[12'h310], 8'hFF);

    // R8: range 2..5 with sector 3 protected
    mem[12'h380] = 8'h12; mem[12'h480] = 8'h00; prot = 16'h0008;
    exp_erase(12'h200, 8'h30, 0); exp_erase(12'h400, 8'h30, 0); exp_erase(12'h500, 8'h30, 0);
    run_op("R8", 1, 12'h200, 12'h5FF, 0, 16'd1000, 0, 0, 8'h30, 2'd0, 0);
    chk(mem[12'h380] == 8'h12, "R8", "protected sector kept", mem[12'h380], 8'h12);
    chk(mem[12'h480] == 8'hFF, "R8", "sector 4 erased", mem[12'h480], 8'hFF);
    prot = '0;

    // R7: device never finishes -> reset at sector base, timeout status
    busy_inf = 1; exp_prog(12'h634, 8'h77, 0); push(12'h600, 8'hF0);
    run_op("R7", 0, 12'h634, 0, 8'h77, 16'd40, 0, 0, 8'h30, 2'd2, 0);
    busy_inf = 0;

    // R11: start while busy is ignored
    busy_len = 6; exp_prog(12'h700, 8'h5A, 0);
    run_op("R11", 0, 12'h700, 0, 8'h5A, 16'd1000, 0, 0, 8'h30, 2'd0, 1);
    repeat (20) @(negedge clk);
    chk(busy === 0, "R11", "no op launched by ignored start", busy, 0);
    chk(mem[12'h0F0] == 8'hFF, "R11", "ignored start left flash", mem[12'h0F0], 8'hFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule